// File: doc/BRIEF.md
# Line Driver Protection Controller

This block supervises a transmit line driver from the digital side. It holds the 5-bit transmit gain code that is applied to the driver. Each step of the code is one dB on a logarithmic scale, and the block reports the matching attenuation. While an over-current comparator bit is high, the applied gain backs off one code per backoff interval so the analog loop can settle between steps. The reduced gain stays in place until the host starts the next transmission. At that point the requested code is loaded again, so the level never recovers in the middle of a frame.

The same block sorts a digital die-temperature reading into four zones and switches the amplifier off when the temperature is far too high. The re-enable point is lower than the trip point, which gives the shutdown hysteresis. A sticky flag records that a thermal trip happened until the host clears it.

Top module: `ldrv_guard`

## Requirements
- R1: After reset the applied gain is 0, the zone is 1 once a cool temperature has been sampled, `pa_en` is 1 and `trip_flag` is 0.
- R2: When `tx_start` is sampled high, the applied gain takes the 5-bit `host_gain` value (0 to 31) at that clock edge. This holds even while `oc_sense` is high.
- R3: `atten_db` is a 6-bit two's complement value equal to the applied gain minus 31. Code 31 gives 0 and code 0 gives -31.
- R4: While `oc_sense` is high and `tx_start` is low, the gain drops by one on the first sampled cycle and then again every BACKOFF_CYC cycles, with BACKOFF_CYC at 4 by default. The interval count restarts whenever `oc_sense` is sampled low.
- R5: The applied gain never goes below code 0.
- R6: While `oc_sense` and `tx_start` are both low, the applied gain holds its value. It does not recover toward `host_gain`.
- R7: `zone` is registered from the unsigned temperature code, read in degrees. It is 1 below 70, 2 from 70 to 99, 3 from 100 to 124 and 4 at 125 and above.
- R8: A temperature code above 170 drives `pa_en` low from the next clock edge. A code of exactly 170 does not trip.
- R9: Once tripped, `pa_en` stays low until a code below 125 is sampled. A code of 125 keeps it low.
- R10: `trip_flag` is set on every thermal trip. It stays set after re-enable, and it is cleared by `trip_clr` when no new trip happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start-of-transmission pulse, loads the host gain |
| host_gain | input | 5 | Gain code requested by the host |
| oc_sense | input | 1 | Over-current comparator output |
| temp_code | input | TEMP_W | Die temperature in degrees, unsigned |
| trip_clr | input | 1 | Host write that clears the sticky trip flag |
| gain_code | output | 5 | Applied transmit gain code |
| atten_db | output | 6 | Attenuation in dB, signed |
| zone | output | 3 | Temperature zone, 1 to 4 |
| pa_en | output | 1 | Amplifier enable |
| trip_flag | output | 1 | Sticky thermal-trip status |

## Verification
Some properties are checked on every cycle. The gain moves by exactly one code on each backoff event and holds between events, a start pulse loads the host code, the gain stops at code 0, and two backoff events never fall on adjacent cycles. On the thermal side, a hot sample always trips, a tripped state holds until the temperature is below 125, every trip sets the flag, and a disabled amplifier always goes with zone 4.

Other behaviour only shows up in the bench's scenarios against its own model. These cases are the exact spacing of steps over long over-current runs, the 170 and 125 boundary codes, the zone edges, and clearing the flag while the amplifier is still off.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;
  localparam int GAIN_W = 5;
  localparam int GAIN_MAX = (1 << GAIN_W) - 1;

  // attenuation in dB relative to full scale: code minus the top code
  function automatic logic signed [GAIN_W:0] gain_to_db(input logic [GAIN_W-1:0] g);
    logic signed [GAIN_W:0] full;
    full = (GAIN_W + 1)'(GAIN_MAX);
    return $signed({1'b0, g}) - full;
  endfunction

  // one code lower, never below zero
  function automatic logic [GAIN_W-1:0] gain_dec(input logic [GAIN_W-1:0] g);
    return (g == '0) ? g : g - GAIN_W'(1);
  endfunction
endpackage

// File: rtl/ldrv_gain_step.sv
module ldrv_gain_step
  import ldrv_pkg::*;
#(
  parameter int BACKOFF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [GAIN_W-1:0] host_gain,
  input  logic              oc_sense,
  output logic [GAIN_W-1:0] gain_q,
  output logic              step_evt
);
  localparam int CW = (BACKOFF_CYC > 1) ? $clog2(BACKOFF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(BACKOFF_CYC - 1);

  logic [CW-1:0] gap_q;

  assign step_evt = !tx_start && oc_sense && (gap_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      gap_q  <= '0;
    end else if (tx_start) begin
      gain_q <= host_gain;
      gap_q  <= '0;
    end else if (oc_sense) begin
      if (gap_q == '0) begin
        gain_q <= gain_dec(gain_q);
        gap_q  <= RELOAD;
      end else begin
        gap_q <= gap_q - CW'(1);
      end
    end else begin
      gap_q <= '0;
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> gain_q == $past(host_gain));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && gain_q != '0) |=> gain_q == $past(gain_q) - GAIN_W'(1));
  // R5
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && gain_q == '0) |=> gain_q == '0);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_start && !oc_sense) |=> $stable(gain_q));

  generate
    if (BACKOFF_CYC > 1) begin : g_gap
      // R4
      spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt |=> !step_evt);
    end
  endgenerate
endmodule

// File: rtl/ldrv_therm.sv
module ldrv_therm #(
  parameter int TEMP_W  = 8,
  parameter int ZONE_T1 = 70,
  parameter int ZONE_T2 = 100,
  parameter int ZONE_T3 = 125,
  parameter int TRIP_T  = 170
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              trip_clr,
  output logic [2:0]        zone_q,
  output logic              trip_q,
  output logic              sticky_q,
  output logic              trip_set
);
  localparam int NB = 3;
  localparam logic [NB*TEMP_W-1:0] BOUNDS =
    {TEMP_W'(ZONE_T3), TEMP_W'(ZONE_T2), TEMP_W'(ZONE_T1)};

  logic [NB-1:0] above;
  logic          hot, cool;
  logic [2:0]    zone_d;

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign above[i] = temp_code >= BOUNDS[i*TEMP_W +: TEMP_W];
  end

  assign zone_d   = 3'd1 + 3'($countones(above));
  assign hot      = temp_code > TEMP_W'(TRIP_T);
  assign cool     = temp_code < TEMP_W'(ZONE_T3);
  assign trip_set = !trip_q && hot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zone_q   <= 3'd1;
      trip_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      zone_q <= zone_d;
      trip_q <= trip_q ? !cool : hot;
      if (trip_set)      sticky_q <= 1'b1;
      else if (trip_clr) sticky_q <= 1'b0;
    end
  end

  // R8
  trip_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> trip_q);
  // R9
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && temp_code >= TEMP_W'(ZONE_T3)) |=> trip_q);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |=> sticky_q);
  // R7
  zone_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(ZONE_T3)) |=> zone_q == 3'd4);
endmodule

// File: rtl/ldrv_guard.sv
module ldrv_guard
  import ldrv_pkg::*;
#(
  parameter int BACKOFF_CYC = 4,
  parameter int TEMP_W      = 8,
  parameter int ZONE_T1     = 70,
  parameter int ZONE_T2     = 100,
  parameter int ZONE_T3     = 125,
  parameter int TRIP_T      = 170
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_start,
  input  logic [GAIN_W-1:0]       host_gain,
  input  logic                    oc_sense,
  input  logic [TEMP_W-1:0]       temp_code,
  input  logic                    trip_clr,
  output logic [GAIN_W-1:0]       gain_code,
  output logic signed [GAIN_W:0]  atten_db,
  output logic [2:0]              zone,
  output logic                    pa_en,
  output logic                    trip_flag
);
  logic step_evt;
  logic trip_q;
  logic trip_set;

  ldrv_gain_step #(.BACKOFF_CYC(BACKOFF_CYC)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_start (tx_start),
    .host_gain(host_gain),
    .oc_sense (oc_sense),
    .gain_q   (gain_code),
    .step_evt (step_evt)
  );

  ldrv_therm #(
    .TEMP_W (TEMP_W),
    .ZONE_T1(ZONE_T1),
    .ZONE_T2(ZONE_T2),
    .ZONE_T3(ZONE_T3),
    .TRIP_T (TRIP_T)
  ) u_therm (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp_code(temp_code),
    .trip_clr (trip_clr),
    .zone_q   (zone),
    .trip_q   (trip_q),
    .sticky_q (trip_flag),
    .trip_set (trip_set)
  );

  assign atten_db = gain_to_db(gain_code);
  assign pa_en    = !trip_q;

  // R9
  off_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_en |-> zone == 3'd4);
  // R3
  atten_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atten_db <= 0);
endmodule

// File: tb/ldrv_guard_tb.sv
module ldrv_guard_tb;
  localparam int BO = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0;
  logic [4:0] host_gain = '0;
  logic       oc_sense = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       trip_clr = 1'b0;
  logic [4:0] gain_code;
  logic signed [5:0] atten_db;
  logic [2:0] zone;
  logic       pa_en;
  logic       trip_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model state
  int m_gain = 0, m_run = 0, m_zone = 1;
  bit m_trip = 0, m_stk = 0;

  always #10 clk = ~clk;

  ldrv_guard #(.BACKOFF_CYC(BO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .host_gain(host_gain),
    .oc_sense(oc_sense), .temp_code(temp_code), .trip_clr(trip_clr),
    .gain_code(gain_code), .atten_db(atten_db), .zone(zone),
    .pa_en(pa_en), .trip_flag(trip_flag)
  );

  function automatic int zone_ref(input int t);
    if (t < 70) return 1;
    if (t < 100) return 2;
    if (t < 125) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_gain = 0; m_run = 0; m_zone = 1; m_trip = 0; m_stk = 0;
    end else begin
      bit was;
      was = m_trip;
      if (tx_start) begin
        m_gain = host_gain; m_run = 0;
      end else if (oc_sense) begin
        if ((m_run % BO) == 0 && m_gain > 0) m_gain--;
        m_run++;
      end else m_run = 0;
      m_zone = zone_ref(temp_code);
      m_trip = was ? (temp_code >= 125) : (temp_code > 170);
      if (!was && temp_code > 170) m_stk = 1;
      else if (trip_clr) m_stk = 0;
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    if (rst_n) begin
      check("R4 gain", int'(gain_code), m_gain);
      check("R3 atten", int'(atten_db), m_gain - 31);
      check("R7 zone", int'(zone), m_zone);
      check("R8 pa_en", int'(pa_en), int'(!m_trip));
      check("R10 flag", int'(trip_flag), int'(m_stk));
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    int r;
    int t;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    check("R1 gain", int'(gain_code), 0);
    check("R1 zone", int'(zone), 1);
    check("R1 pa_en", int'(pa_en), 1);
    check("R1 flag", int'(trip_flag), 0);

    tx_start = 1'b1; host_gain = 5'd31;
    tick(1);
    tx_start = 1'b0;
    check("R2 load", int'(gain_code), 31);
    check("R3 full", int'(atten_db), 0);

    oc_sense = 1'b1;
    tick(1);
    check("R4 first", int'(gain_code), 30);
    tick(3);
    check("R4 wait", int'(gain_code), 30);
    tick(1);
    check("R4 second", int'(gain_code), 29);
    oc_sense = 1'b0;
    tick(10);
    check("R6 hold", int'(gain_code), 29);
    oc_sense = 1'b1;
    tick(200);
    check("R5 floor", int'(gain_code), 0);
    check("R3 min", int'(atten_db), -31);
    tx_start = 1'b1; host_gain = 5'd17;
    tick(1);
    tx_start = 1'b0; oc_sense = 1'b0;
    check("R2 over oc", int'(gain_code), 17);

    temp_code = 8'd170;
    tick(1);
    check("R8 edge", int'(pa_en), 1);
    check("R7 z4", int'(zone), 4);
    temp_code = 8'd171;
    tick(1);
    check("R8 trip", int'(pa_en), 0);
    check("R10 set", int'(trip_flag), 1);
    temp_code = 8'd125;
    tick(3);
    check("R9 hold", int'(pa_en), 0);
    trip_clr = 1'b1;
    tick(1);
    trip_clr = 1'b0;
    check("R10 clear", int'(trip_flag), 0);
    check("R9 still off", int'(pa_en), 0);
    temp_code = 8'd124;
    tick(1);
    check("R9 release", int'(pa_en), 1);
    check("R7 z3", int'(zone), 3);
    temp_code = 8'd70;  tick(1); check("R7 z2", int'(zone), 2);
    temp_code = 8'd69;  tick(1); check("R7 z1", int'(zone), 1);
    temp_code = 8'd100; tick(1); check("R7 z3b", int'(zone), 3);

    t = 100;
    for (int k = 0; k < 3000; k++) begin
      tx_start  = ($urandom % 20) == 0;
      host_gain = 5'($urandom);
      oc_sense  = ($urandom % 10) < 4;
      trip_clr  = ($urandom % 30) == 0;
      if (($urandom % 50) == 0) t = int'($urandom % 256);
      else t = t + int'($urandom % 17) - 8;
      if (t < 0) t = 0;
      if (t > 255) t = 255;
      temp_code = 8'(t);
      tick(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule